// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Event Controller

This block watches a word of asynchronous input lines and turns edges on them into sticky pending flags. Each line that exists in the build can be set up to react to a low-to-high transition, a high-to-low transition, or both. Software can also raise a line's pending flag by itself through a trigger register. The flag stays set until software clears it by writing a one to it.

Two mask words decide what a pending line does. The interrupt mask lets the flag contribute to a single level interrupt request. The event mask lets each new trigger produce a one-cycle event pulse on that line's event output. Registers are reached through a plain write strobe, a byte address and a combinational read path. Only some bit positions are backed by real lines. The remaining positions always read as zero and ignore writes.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, all six registers read 0x00000000, `irqOut` is 0 and `eventOut` is all zeros.
- R2: Only the bit positions set in `IMPL_MASK` exist; by default this is 0x807BFFFF, meaning lines 0..17, 19..22 and 31. In every register, the other positions read 0 and writes to them are discarded.
- R3: The registers sit at these byte offsets: 0x00 interrupt mask, 0x04 event mask, 0x08 rising-edge enable, 0x0C falling-edge enable, 0x10 software trigger, 0x14 pending. A write changes only the register it addresses.
- R4: A 0-to-1 change on a line whose rising enable is 1 sets that line's pending bit. The bit reads set in the cycle after the third rising clock edge following the input change: two synchronizer stages plus the pending register. A rising edge on a line whose rising enable is 0 sets nothing.
- R5: A 1-to-0 change on a line whose falling enable is 1 sets its pending bit with the same latency as R4. When both enables are 1, either edge sets it. A falling edge on a line with only its rising enable set sets nothing.
- R6: An edge detected in the same cycle as a write to the rising-enable or the falling-enable register is dropped, and no pending bit is set by it.
- R7: Writing 1 to a software-trigger bit that reads 0 sets that bit and the line's pending bit on the same clock edge.
- R8: A software-trigger bit that is set stays set when software writes 0 to it. It clears only when a 1 is written to the matching pending bit.
- R9: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. If a trigger for that line occurs in the same cycle as the clear, the bit stays set.
- R10: `irqOut` is 1 exactly when some line has both its pending bit and its interrupt-mask bit at 1.
- R11: A trigger on a line whose event-mask bit is 1 produces a pulse on that line's `eventOut` bit. The pulse is one cycle long and appears in the cycle after the triggering clock edge. Lines whose event mask is 0 produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lineIn | input | NUM_LINES | Asynchronous external lines |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte address for reads and writes |
| regWrData | input | NUM_LINES | Write data |
| regRdData | output | NUM_LINES | Read data for `regAddr`, combinational |
| irqOut | output | 1 | Level interrupt request |
| eventOut | output | NUM_LINES | Per-line one-cycle event pulses |

## Verification
The bench uses the defaults: 32 lines, implemented map 0x807BFFFF and two synchronizer stages. This map puts the lone reserved bit 18 between live lines 17 and 19, and puts the top line 31 past a block of reserved bits, so reserved-bit masking and the highest live line are both exercised. With the fixed three-clock edge latency, the bench can place a register write or a pending clear in exactly the cycle in which an edge is detected. That makes the suppression and clear-versus-trigger corner cases reachable with directed timing.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int unsigned OFF_INT_MASK = 'h00;
  localparam int unsigned OFF_EVT_MASK = 'h04;
  localparam int unsigned OFF_RISE     = 'h08;
  localparam int unsigned OFF_FALL     = 'h0C;
  localparam int unsigned OFF_SW       = 'h10;
  localparam int unsigned OFF_PEND     = 'h14;

  typedef struct packed {
    logic intMask;
    logic evtMask;
    logic rise;
    logic fall;
    logic swTrig;
    logic pend;
  } regStrobe_t;

  typedef enum logic [2:0] {
    SEL_INT, SEL_EVT, SEL_RISE, SEL_FALL, SEL_SW, SEL_PEND, SEL_NONE
  } rdSel_e;
endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ[0] <= '0;
    else       stageQ[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ[g] <= '0;
      else       stageQ[g] <= stageQ[g-1];
    end
  end

  assign dout = stageQ[STAGES-1];
endmodule

// File: rtl/edge_irq_decode.sv
module edge_irq_decode
  import edge_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        wrStb,
  output rdSel_e            rdSel
);
  always_comb begin
    rdSel = SEL_NONE;
    if      (regAddr == ADDR_W'(OFF_INT_MASK)) rdSel = SEL_INT;
    else if (regAddr == ADDR_W'(OFF_EVT_MASK)) rdSel = SEL_EVT;
    else if (regAddr == ADDR_W'(OFF_RISE))     rdSel = SEL_RISE;
    else if (regAddr == ADDR_W'(OFF_FALL))     rdSel = SEL_FALL;
    else if (regAddr == ADDR_W'(OFF_SW))       rdSel = SEL_SW;
    else if (regAddr == ADDR_W'(OFF_PEND))     rdSel = SEL_PEND;
  end

  always_comb begin
    wrStb         = '0;
    wrStb.intMask = regWrEn && (rdSel == SEL_INT);
    wrStb.evtMask = regWrEn && (rdSel == SEL_EVT);
    wrStb.rise    = regWrEn && (rdSel == SEL_RISE);
    wrStb.fall    = regWrEn && (rdSel == SEL_FALL);
    wrStb.swTrig  = regWrEn && (rdSel == SEL_SW);
    wrStb.pend    = regWrEn && (rdSel == SEL_PEND);
  end
endmodule

// File: rtl/edge_irq_datapath.sv
module edge_irq_datapath
  import edge_irq_pkg::*;
#(
  parameter int unsigned      NUM_LINES = 32,
  parameter logic [NUM_LINES-1:0] IMPL_MASK = 32'h807B_FFFF,
  parameter int unsigned      STAGES    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] lineIn,
  input  regStrobe_t           wrStb,
  input  rdSel_e               rdSel,
  input  logic [NUM_LINES-1:0] wrData,
  output logic [NUM_LINES-1:0] rdData,
  output logic                 irqOut,
  output logic [NUM_LINES-1:0] eventOut
);
  logic [NUM_LINES-1:0] lineSync, prevQ;
  logic [NUM_LINES-1:0] intMaskQ, evtMaskQ, riseEnQ, fallEnQ, swQ, pendQ;
  logic [NUM_LINES-1:0] implData, hwTrig, swSet, clrVec, trigVec;
  logic                 edgeBlock;

  edge_irq_sync #(.WIDTH(NUM_LINES), .STAGES(STAGES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (lineIn & IMPL_MASK),
    .dout(lineSync)
  );

  assign implData  = wrData & IMPL_MASK;
  assign edgeBlock = wrStb.rise | wrStb.fall;
  assign hwTrig    = ((riseEnQ & lineSync & ~prevQ) | (fallEnQ & ~lineSync & prevQ))
                     & {NUM_LINES{~edgeBlock}};
  assign swSet     = wrStb.swTrig ? (implData & ~swQ) : '0;
  assign clrVec    = wrStb.pend ? implData : '0;
  assign trigVec   = hwTrig | swSet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ    <= '0;
      intMaskQ <= '0;
      evtMaskQ <= '0;
      riseEnQ  <= '0;
      fallEnQ  <= '0;
      swQ      <= '0;
      pendQ    <= '0;
      eventOut <= '0;
    end else begin
      prevQ <= lineSync;
      if (wrStb.intMask) intMaskQ <= implData;
      if (wrStb.evtMask) evtMaskQ <= implData;
      if (wrStb.rise)    riseEnQ  <= implData;
      if (wrStb.fall)    fallEnQ  <= implData;
      swQ      <= swSet | (swQ & ~clrVec);
      pendQ    <= trigVec | (pendQ & ~clrVec);
      eventOut <= trigVec & evtMaskQ;
    end
  end

  assign irqOut = |(pendQ & intMaskQ);

  always_comb begin
    unique case (rdSel)
      SEL_INT:  rdData = intMaskQ;
      SEL_EVT:  rdData = evtMaskQ;
      SEL_RISE: rdData = riseEnQ;
      SEL_FALL: rdData = fallEnQ;
      SEL_SW:   rdData = swQ;
      SEL_PEND: rdData = pendQ;
      default:  rdData = '0;
    endcase
  end

  // R2: reserved positions never show up on the read path
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & ~IMPL_MASK) == '0);

  // R6: no pending bit appears right after an enable-register write
  p_edge_block_r6: assert property (@(posedge clk) disable iff (!rstN)
    edgeBlock |=> ((pendQ & ~$past(pendQ)) == '0));

  // R8: a software-trigger bit only drops when its pending bit is cleared
  p_sw_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(swQ) & ~swQ & ~$past(clrVec)) == '0));

  // R9: a pending bit only drops on a write-one clear
  p_pend_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(pendQ) & ~pendQ & ~$past(clrVec)) == '0));

  // R10: the request needs some pending line
  p_irq_src_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (pendQ != '0));

  // R11: an event pulse needs an open event mask
  p_evt_mask_r11: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((eventOut & ~$past(evtMaskQ)) == '0));
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int unsigned          NUM_LINES = 32,
  parameter logic [NUM_LINES-1:0] IMPL_MASK = 32'h807B_FFFF,
  parameter int unsigned          STAGES    = 2,
  parameter int unsigned          ADDR_W    = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] lineIn,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [NUM_LINES-1:0] regWrData,
  output logic [NUM_LINES-1:0] regRdData,
  output logic                 irqOut,
  output logic [NUM_LINES-1:0] eventOut
);
  regStrobe_t wrStb;
  rdSel_e     rdSel;

  edge_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .regWrEn(regWrEn),
    .regAddr(regAddr),
    .wrStb  (wrStb),
    .rdSel  (rdSel)
  );

  edge_irq_datapath #(
    .NUM_LINES(NUM_LINES),
    .IMPL_MASK(IMPL_MASK),
    .STAGES   (STAGES)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .lineIn  (lineIn),
    .wrStb   (wrStb),
    .rdSel   (rdSel),
    .wrData  (regWrData),
    .rdData  (regRdData),
    .irqOut  (irqOut),
    .eventOut(eventOut)
  );
endmodule

// File: tb/edge_irq_ctrl_tb.sv
module edge_irq_ctrl_tb;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned N = 32;
  localparam logic [N-1:0] IMPL = 32'h807B_FFFF;
  localparam logic [4:0] A_INT = 5'h00, A_EVT = 5'h04, A_RISE = 5'h08,
                         A_FALL = 5'h0C, A_SW = 5'h10, A_PEND = 5'h14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] lineIn = '0;
  logic regWrEn = 1'b0;
  logic [4:0] regAddr = '0;
  logic [N-1:0] regWrData = '0;
  logic [N-1:0] regRdData;
  logic irqOut;
  logic [N-1:0] eventOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_irq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut), .eventOut(eventOut)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [N-1:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rdChk(input string req, input logic [4:0] a, input logic [N-1:0] exp);
    regAddr = a;
    #1;
    chk(req, regRdData, exp);
  endtask

  task automatic t_reset;
    rdChk("R1 int", A_INT, '0);
    rdChk("R1 evt", A_EVT, '0);
    rdChk("R1 rise", A_RISE, '0);
    rdChk("R1 fall", A_FALL, '0);
    rdChk("R1 sw", A_SW, '0);
    rdChk("R1 pend", A_PEND, '0);
    chk("R1 irq", N'(irqOut), '0);
    chk("R1 event", eventOut, '0);
  endtask

  task automatic t_map;
    wr(A_INT, '1);
    rdChk("R2 reserved bits", A_INT, IMPL);
    wr(A_EVT, 32'h0000_0011);
    wr(A_RISE, 32'h0000_0022);
    wr(A_FALL, 32'h0000_0044);
    rdChk("R3 int offset", A_INT, IMPL);
    rdChk("R3 evt offset", A_EVT, 32'h0000_0011);
    rdChk("R3 rise offset", A_RISE, 32'h0000_0022);
    rdChk("R3 fall offset", A_FALL, 32'h0000_0044);
    rdChk("R3 pend untouched", A_PEND, '0);
    wr(A_INT, '0); wr(A_EVT, '0); wr(A_RISE, '0); wr(A_FALL, '0);
  endtask

  task automatic t_rise;
    wr(A_RISE, 32'h8000_0001);
    wr(A_EVT, 32'h0000_0001);
    lineIn[0] = 1'b1; lineIn[31] = 1'b1; lineIn[5] = 1'b1;
    cyc(2);
    rdChk("R4 not before latency", A_PEND, '0);
    cyc(1);
    rdChk("R4 rising sets", A_PEND, 32'h8000_0001);
    chk("R11 pulse", eventOut, 32'h0000_0001);
    chk("R10 masked", N'(irqOut), '0);
    cyc(1);
    chk("R11 one cycle", eventOut, '0);
    wr(A_INT, 32'h8000_0000);
    chk("R10 irq on", N'(irqOut), 1);
    wr(A_PEND, 32'h0000_0001);
    rdChk("R9 clear one", A_PEND, 32'h8000_0000);
    wr(A_PEND, '0);
    rdChk("R9 zero no effect", A_PEND, 32'h8000_0000);
    chk("R10 still on", N'(irqOut), 1);
    wr(A_PEND, 32'h8000_0000);
    chk("R10 irq off", N'(irqOut), '0);
    wr(A_EVT, '0);
  endtask

  task automatic t_fall;
    wr(A_RISE, 32'h8000_0002);
    wr(A_FALL, 32'h0000_0003);
    lineIn[0] = 1'b0; lineIn[1] = 1'b1;
    cyc(3);
    rdChk("R5 fall and rise", A_PEND, 32'h0000_0003);
    wr(A_PEND, '1);
    lineIn[1] = 1'b0; lineIn[31] = 1'b0;
    cyc(3);
    rdChk("R5 both edges, rise-only ignores fall", A_PEND, 32'h0000_0002);
    wr(A_PEND, '1);
  endtask

  task automatic t_block;
    lineIn[1] = 1'b1;
    cyc(2);
    wr(A_RISE, 32'h8000_0002);
    cyc(2);
    rdChk("R6 edge dropped", A_PEND, '0);
    lineIn[1] = 1'b0;
    cyc(3);
    rdChk("R6 later edge works", A_PEND, 32'h0000_0002);
    wr(A_PEND, '1);
  endtask

  task automatic t_clrRace;
    lineIn[1] = 1'b1;
    cyc(3);
    rdChk("R9 setup", A_PEND, 32'h0000_0002);
    lineIn[1] = 1'b0;
    cyc(2);
    wr(A_PEND, 32'h0000_0002);
    rdChk("R9 trigger beats clear", A_PEND, 32'h0000_0002);
    wr(A_PEND, 32'h0000_0002);
    rdChk("R9 cleared", A_PEND, '0);
  endtask

  task automatic t_soft;
    wr(A_SW, 32'h000C_0004);
    rdChk("R7 sw set", A_SW, 32'h0008_0004);
    rdChk("R7 pend set", A_PEND, 32'h0008_0004);
    wr(A_PEND, 32'h0000_0004);
    rdChk("R8 sw cleared by pend", A_SW, 32'h0008_0000);
    wr(A_SW, '0);
    rdChk("R8 zero write holds", A_SW, 32'h0008_0000);
    wr(A_PEND, 32'h0008_0000);
    rdChk("R8 sw cleared", A_SW, '0);
    wr(A_EVT, 32'h0000_0001);
    wr(A_SW, 32'h0000_0001);
    chk("R11 sw event", eventOut, 32'h0000_0001);
    cyc(1);
    chk("R11 sw event ends", eventOut, '0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rstN = 1'b1;
        t_reset();
        t_map();
        t_rise();
        t_fall();
        t_block();
        t_clrRace();
        t_soft();
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog actual=timeout expected=finish");
        end
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule